// File: doc/BRIEF.md
# Multi-Cycle 32-bit Subset Processor Core

This core runs a small 32-bit load/store instruction subset. It has no pipeline, and every instruction takes several clock cycles. A single synchronous memory port carries both instruction fetches and data accesses. One adder/logic unit does all of the arithmetic: the program-counter step, the branch target, the effective address and register-to-register operations. The values that pass between steps sit in holding registers: the instruction word, the two operands and the unit result.

A hardwired state machine steps through fetch, decode and a short sequence that depends on the instruction class. The next state depends only on the current state and the class seen in decode. During decode the core always forms the branch target, before it knows whether the instruction is a branch. The memory returns read data one cycle after the address is presented. So the decode step reads the instruction straight from the port, and a load's write-back takes its data straight from the port. The current program counter and the controller state are brought out for debug.

Top module: `mc_core`

## Requirements
- R1: While reset (active-low `rst_n`) is held, and at the first clock after it is released, `dbg_pc` is 0 and `dbg_state` is 0, which is the fetch state.
- R2: The fetch state (code 0) presents PC on `mem_addr` with `mem_we` low and adds 4 to PC. The next state is decode (code 1). Decode reads source registers from instruction bits 25:21 and 20:16.
- R3: Instructions take these cycle counts: load 5, store 4, register-format 4, branch 3, jump 3, unsupported opcode 2.
- R4: A load (opcode 0x23) reads the word at base register plus the sign-extended bits 15:0. It writes that word into the register named by bits 20:16. A store (opcode 0x2B) writes the register named by bits 20:16 to the same kind of address, with `mem_we` high for one cycle.
- R5: Register-format instructions (opcode 0x00) write their result into the register named by bits 15:11. The function codes in bits 5:0 are: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0).
- R6: Branch-on-equal (opcode 0x04) compares the registers named by bits 25:21 and 20:16. If they are equal, PC becomes the incremented PC plus the sign-extended bits 15:0 shifted left by 2. If not, execution continues with the next instruction.
- R7: Jump (opcode 0x02) sets PC to the upper 4 bits of the incremented PC followed by bits 25:0 and two zero bits.
- R8: Register 0 always reads as zero, and writes to it are dropped.
- R9: An unsupported opcode changes no register and no memory word. The core continues with the next sequential instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 32 | Byte address for fetch, load or store |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write enable for a store |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| dbg_pc | output | 32 | Current program counter |
| dbg_state | output | 4 | Current controller state code |

## Verification
The program's operands are random, plus directed pairs: equal values, which turn the not-taken branch into a taken one, and sign-boundary values for the signed set-less-than. A core that compared without sign, or that sampled read data one cycle too early, would store the wrong words to the result region. A write to register 0 followed by a store of register 0 exposes a register file that keeps the value. Marker words sit behind the taken branch, behind the jump and at the address an unsupported opcode would write if it were mistaken for a store. Any wrong redirect, or any stray write, overwrites one of those markers. The program counter and state are sampled at exact cycle counts, so a class that spends one cycle too many or too few is caught.

// File: rtl/mc_core.sv
module mc_core #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_we,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] dbg_pc,
  output logic [3:0]      dbg_state
);
  localparam int RIDX = $clog2(NREG);

  typedef enum logic [3:0] {
    S_FETCH = 4'd0, S_DECODE = 4'd1, S_ADDR = 4'd2, S_LDRD = 4'd3,
    S_LDWB  = 4'd4, S_STWR   = 4'd5, S_REXE = 4'd6, S_RWB  = 4'd7,
    S_BEQ   = 4'd8, S_JMP    = 4'd9
  } state_t;

  typedef enum logic [2:0] {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_SLT} aop_t;

  state_t state, nxt;
  logic [XLEN-1:0] pc, ir, a_r, b_r, alu_q;
  logic [XLEN-1:0] rf [0:NREG-1];
  logic [XLEN-1:0] alu_a, alu_b, alu_y;
  aop_t aop;

  wire [5:0] dop   = mem_rdata[31:26];
  wire [5:0] dfn   = mem_rdata[5:0];
  wire [XLEN-1:0] sext_d = {{(XLEN-16){mem_rdata[15]}}, mem_rdata[15:0]};
  wire [XLEN-1:0] sext_i = {{(XLEN-16){ir[15]}}, ir[15:0]};
  wire [RIDX-1:0] rs_d = mem_rdata[25:21];
  wire [RIDX-1:0] rt_d = mem_rdata[20:16];
  wire [RIDX-1:0] rt_i = ir[20:16];
  wire [RIDX-1:0] rd_i = ir[15:11];
  wire fn_ok = (dfn == 6'h20) || (dfn == 6'h22) || (dfn == 6'h24) ||
               (dfn == 6'h25) || (dfn == 6'h2A);

  assign mem_addr  = (state == S_FETCH) ? pc : alu_q;
  assign mem_we    = (state == S_STWR);
  assign mem_wdata = b_r;
  assign dbg_pc    = pc;
  assign dbg_state = state;

  assign alu_a = (state == S_FETCH || state == S_DECODE) ? pc : a_r;

  always_comb begin
    case (state)
      S_FETCH:  alu_b = XLEN'(4);
      S_DECODE: alu_b = {sext_d[XLEN-3:0], 2'b00};
      S_ADDR:   alu_b = sext_i;
      default:  alu_b = b_r;
    endcase
  end

  always_comb begin
    aop = OP_ADD;
    if (state == S_BEQ) aop = OP_SUB;
    else if (state == S_REXE) begin
      case (ir[5:0])
        6'h22:   aop = OP_SUB;
        6'h24:   aop = OP_AND;
        6'h25:   aop = OP_OR;
        6'h2A:   aop = OP_SLT;
        default: aop = OP_ADD;
      endcase
    end
  end

  always_comb begin
    case (aop)
      OP_SUB:  alu_y = alu_a - alu_b;
      OP_AND:  alu_y = alu_a & alu_b;
      OP_OR:   alu_y = alu_a | alu_b;
      OP_SLT:  alu_y = {{(XLEN-1){1'b0}}, $signed(alu_a) < $signed(alu_b)};
      default: alu_y = alu_a + alu_b;
    endcase
  end

  always_comb begin
    nxt = S_FETCH;
    case (state)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (dop)
          6'h23, 6'h2B: nxt = S_ADDR;
          6'h00:        nxt = fn_ok ? S_REXE : S_FETCH;
          6'h04:        nxt = S_BEQ;
          6'h02:        nxt = S_JMP;
          default:      nxt = S_FETCH;
        endcase
      end
      S_ADDR:   nxt = (ir[31:26] == 6'h23) ? S_LDRD : S_STWR;
      S_LDRD:   nxt = S_LDWB;
      S_REXE:   nxt = S_RWB;
      default:  nxt = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
    end else begin
      state <= nxt;
      if (state == S_FETCH) pc <= alu_y;
      if (state == S_BEQ && alu_y == '0) pc <= alu_q;
      if (state == S_JMP) pc <= {pc[XLEN-1:28], ir[25:0], 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_DECODE) begin
      ir  <= mem_rdata;
      a_r <= (rs_d == '0) ? '0 : rf[rs_d];
      b_r <= (rt_d == '0) ? '0 : rf[rt_d];
    end
    if (state == S_DECODE || state == S_ADDR || state == S_REXE) alu_q <= alu_y;
  end

  always_ff @(posedge clk) begin
    if (state == S_LDWB && rt_i != '0) rf[rt_i] <= mem_rdata;
    if (state == S_RWB && rd_i != '0)  rf[rd_i] <= alu_q;
  end

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FETCH |=> state == S_DECODE);
  p_fetch_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FETCH |=> pc == $past(pc) + XLEN'(4));
  p_store_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we && state == S_FETCH);
  p_load_three_after_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_LDRD |=> state == S_LDWB);
  p_beq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BEQ && a_r != b_r) |=> $stable(pc));
  p_beq_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BEQ && a_r == b_r) |=> pc == $past(alu_q));
  p_jump_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_JMP |=> pc[XLEN-1:28] == $past(pc[XLEN-1:28]) && pc[1:0] == 2'b00);
  p_zero_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DECODE && rs_d == '0) |=> a_r == '0);
  p_illegal_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DECODE && !(dop inside {6'h23, 6'h2B, 6'h00, 6'h04, 6'h02}))
      |=> state == S_FETCH);
  p_state_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state <= S_JMP);
endmodule

// File: tb/mc_core_test.sv
module mc_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, dbg_pc;
  logic mem_we;
  logic [3:0] dbg_state;
  logic [31:0] mem [0:255];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mc_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .dbg_pc(dbg_pc), .dbg_state(dbg_state)
  );

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:2]];
  end

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] sentinel(int idx);
    return 32'hDEAD0000 | 32'(idx);
  endfunction

  function automatic logic [31:0] exp_word(int idx, logic [31:0] x, logic [31:0] y);
    case (idx)
      68: return x + y;
      69: return x - y;
      70: return x & y;
      71: return x | y;
      72: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      73: return 32'd0;
      75: return (x == y) ? sentinel(idx) : y;
      77: return y;
      default: return sentinel(idx);
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic load_prog(logic [31:0] x, logic [31:0] y);
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    for (int i = 64; i < 80; i++) mem[i] = sentinel(i);
    mem[64] = x;
    mem[65] = y;
    mem[0]  = enc_i(6'h23, 0, 1, 16'h0100);
    mem[1]  = enc_i(6'h23, 0, 2, 16'h0104);
    mem[2]  = enc_r(1, 2, 3, 6'h20);
    mem[3]  = enc_r(1, 2, 4, 6'h22);
    mem[4]  = enc_r(1, 2, 5, 6'h24);
    mem[5]  = enc_r(1, 2, 6, 6'h25);
    mem[6]  = enc_r(1, 2, 7, 6'h2A);
    for (int k = 0; k < 5; k++) mem[7+k] = enc_i(6'h2B, 0, 5'(3+k), 16'(16'h0110 + 4*k));
    mem[12] = enc_r(1, 2, 0, 6'h20);
    mem[13] = enc_i(6'h2B, 0, 0, 16'h0124);
    mem[14] = enc_i(6'h04, 1, 1, 16'd2);
    mem[15] = enc_i(6'h2B, 0, 1, 16'h0128);
    mem[16] = enc_i(6'h2B, 0, 1, 16'h0128);
    mem[17] = enc_i(6'h04, 1, 2, 16'd1);
    mem[18] = enc_i(6'h2B, 0, 2, 16'h012C);
    mem[19] = {6'h3F, 5'd0, 5'd2, 16'h0128};
    mem[20] = {6'h02, 26'd22};
    mem[21] = enc_i(6'h2B, 0, 1, 16'h0130);
    mem[22] = enc_i(6'h2B, 0, 2, 16'h0134);
    mem[23] = {6'h02, 26'd23};
  endtask

  task automatic run(logic [31:0] x, logic [31:0] y);
    int total;
    @(negedge clk);
    rst_n = 1'b0;
    load_prog(x, y);
    @(negedge clk);
    chk("R1 reset pc", dbg_pc, 32'd0);
    chk("R1 reset state", 32'(dbg_state), 32'd0);
    rst_n = 1'b1;
    chk("R1 state after release", 32'(dbg_state), 32'd0);
    @(negedge clk);
    chk("R2 decode state", 32'(dbg_state), 32'd1);
    chk("R2 pc step", dbg_pc, 32'd4);
    repeat (4) @(negedge clk);
    chk("R3 load 5 cycles state", 32'(dbg_state), 32'd0);
    chk("R3 load 5 cycles pc", dbg_pc, 32'd4);
    total = (x == y) ? 73 : 77;
    repeat (total - 5) @(negedge clk);
    chk("R3 R7 halt reached state", 32'(dbg_state), 32'd0);
    chk("R3 R7 halt reached pc", dbg_pc, 32'd92);
    repeat (6) @(negedge clk);
    chk("R4 R5 add", mem[68], exp_word(68, x, y));
    chk("R5 sub", mem[69], exp_word(69, x, y));
    chk("R5 and", mem[70], exp_word(70, x, y));
    chk("R5 or", mem[71], exp_word(71, x, y));
    chk("R5 slt signed", mem[72], exp_word(72, x, y));
    chk("R8 r0 zero", mem[73], exp_word(73, x, y));
    chk("R6 R9 skipped and untouched", mem[74], exp_word(74, x, y));
    chk("R6 beq equal test", mem[75], exp_word(75, x, y));
    chk("R7 jump skip", mem[76], exp_word(76, x, y));
    chk("R7 jump target", mem[77], exp_word(77, x, y));
    chk("R4 operand kept", mem[64], x);
  endtask

  initial begin
    logic [31:0] x, y;
    void'($urandom(32'd20240611));
    run(32'h0000_0005, 32'h0000_0005);
    run(32'h8000_0000, 32'h0000_0001);
    run(32'h0000_0001, 32'h8000_0000);
    run(32'hFFFF_FFFF, 32'h0000_0000);
    for (int n = 0; n < 8; n++) begin
      x = $urandom;
      y = $urandom;
      if (n == 3) y = x;
      run(x, y);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule